// File: doc/BRIEF.md
# Machine Error Fault Capture

This block gathers hardware fault conditions into a sticky fault word and turns that word into the interrupt 1 request of a processor's pending interrupt register. Fault lines (memory protection, parity, external address error, system and external fault inputs) are sampled when the bus address strobe falls, so that faults raised by peripherals that own the bus at that moment are taken in step with the bus cycle. A privileged-instruction violation, reported by the core as a check strobe together with a nonzero processor state, sets its own fault bit directly at the next clock.

In B mode the fault word passes through a software-written fault mask before it can request interrupt 1; in A mode every fault bit requests it. The interrupt 1 request cannot be disabled. Servicing the interrupt clears only the pending bit, never the fault word, so an arm flag prevents the still-set word from requesting again: a second request is possible only after the masked fault word has returned to zero, which normally means software has read and cleared the fault register. The pending bit is set on the same clock edge that loads the fault word, with no extra latch stage between them. Two pulse outputs ask the core to abort the current instruction or the next external cycle; the abort itself is handled elsewhere.

Top module: `mef_capture`

## Requirements
- R1: After synchronous reset the fault word reads 0, the fault mask reads all ones, pend1_o is 0, arming is set, and both abort pulses are 0.
- R2: The address strobe passes through SYNC_STAGES (default 2) clock synchronizer flops; a high-to-low transition of the synchronized strobe ORs flt_i, sampled on that clock edge, into the fault word. Fault bits are sticky, and flt_i changes with no strobe fall leave the fault word unchanged.
- R3: When priv_chk_i is 1 and ps_i is nonzero at a clock edge, fault bit PRIV_BIT (default 10) is set at that edge without any strobe; with ps_i equal to 0 the check has no effect.
- R4: pend1_o is set on the same clock edge on which the masked fault word (computed from the fault word and mask after that edge) becomes nonzero while arming is set; it is never set by a zero fault word.
- R5: With b_mode_i = 1 the masked fault word is the fault word ANDed with the fault mask; with b_mode_i = 0 it is the fault word unmasked. fmask_we_i writes fmask_wd_i into the mask at the next edge, and fmask_o reads it back.
- R6: Setting pend1_o clears arming; while arming is clear pend1_o cannot be set again. Arming returns at any edge where the masked fault word is zero.
- R7: ft_clr_i clears the fault word at the next edge; bits captured or raised on that same edge are still set.
- R8: svc_ack_i clears pend1_o at the next edge, except when pend1_o is being set on that edge, in which case the set wins.
- R9: abort_cur_o is a one-cycle pulse on the capture edge when the captured flt_i has the memory-protect bit (MPROT_BIT, default 3) or external-address bit (EXAD_BIT, default 5) set; abort_next_o is a one-cycle pulse on the capture edge when the parity bit (PAR_BIT, default 2) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| as_i | input | 1 | Bus address strobe, asynchronous, idles high |
| flt_i | input | FW | Fault lines, sampled on a synchronized strobe fall |
| priv_chk_i | input | 1 | Privileged instruction is executing this cycle |
| ps_i | input | PS_W | Current processor state |
| b_mode_i | input | 1 | 1 selects B mode (mask applied), 0 selects A mode |
| fmask_we_i | input | 1 | Fault mask write enable |
| fmask_wd_i | input | FW | Fault mask write data |
| ft_clr_i | input | 1 | Clear the fault register |
| svc_ack_i | input | 1 | Interrupt 1 serviced: clear the pending bit |
| ft_o | output | FW | Fault register read value |
| fmask_o | output | FW | Fault mask read value |
| pend1_o | output | 1 | Pending interrupt 1 bit |
| abort_cur_o | output | 1 | Abort the current instruction (pulse) |
| abort_next_o | output | 1 | Abort the next external cycle (pulse) |

## Verification
The assertions watch, on every cycle, that fault bits stay set unless a clear was applied, that no bit appears without a strobe fall or privilege violation, that a clear empties the word, that a rising pend1_o always has a nonzero fault word and a cleared arm flag, that no request arises while disarmed, that an acknowledge clears the pending bit, and that an abort pulse matches a captured cause. Only the bench's scenarios show the strobe synchronizer latency, that a persistent fault does not re-request after service until software clears it, that B mode masking and a later mask write gate and then release the request, and the tie-breaks where a clear or acknowledge meets a capture on the same edge.

// File: rtl/mef_pkg.sv
package mef_pkg;
  typedef enum logic {
    FM_MODE_A = 1'b0,
    FM_MODE_B = 1'b1
  } fm_mode_e;
endpackage

// File: rtl/mef_strobe_sync.sv
module mef_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic as_i,
  output logic fall_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          prev_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= as_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b1;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[LAST];
  end

  assign fall_o = prev_q & ~chain_q[LAST];
endmodule

// File: rtl/mef_fault_store.sv
module mef_fault_store #(
  parameter int FW        = 16,
  parameter int PRIV_BIT  = 10,
  parameter int MPROT_BIT = 3,
  parameter int EXAD_BIT  = 5,
  parameter int PAR_BIT   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fall_i,
  input  logic [FW-1:0] flt_i,
  input  logic          priv_i,
  input  logic          clr_i,
  input  logic          mask_we_i,
  input  logic [FW-1:0] mask_wd_i,
  output logic [FW-1:0] ft_q,
  output logic [FW-1:0] mask_q,
  output logic [FW-1:0] ft_n,
  output logic [FW-1:0] mask_n,
  output logic          abort_cur_q,
  output logic          abort_next_q
);
  localparam logic [FW-1:0] PRIV_ONE = FW'(1) << PRIV_BIT;

  logic [FW-1:0] captured;
  logic [FW-1:0] kept;

  always_comb begin
    captured = fall_i ? flt_i : '0;
    kept     = clr_i ? '0 : ft_q;
    ft_n     = kept | captured | (priv_i ? PRIV_ONE : '0);
    mask_n   = mask_we_i ? mask_wd_i : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ft_q         <= '0;
      mask_q       <= '1;
      abort_cur_q  <= 1'b0;
      abort_next_q <= 1'b0;
    end else begin
      ft_q         <= ft_n;
      mask_q       <= mask_n;
      abort_cur_q  <= fall_i & (flt_i[MPROT_BIT] | flt_i[EXAD_BIT]);
      abort_next_q <= fall_i & flt_i[PAR_BIT];
    end
  end

  AST_FT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr_i)) |-> ((ft_q & $past(ft_q)) == $past(ft_q))); // R2

  AST_NO_SPURIOUS_BIT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(fall_i) && !$past(priv_i)) |-> ((ft_q & ~$past(ft_q)) == '0)); // R2

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(clr_i) && !$past(fall_i) && !$past(priv_i)) |-> (ft_q == '0)); // R7

  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    abort_cur_q |-> (ft_q[MPROT_BIT] | ft_q[EXAD_BIT])); // R9
endmodule

// File: rtl/mef_int1_gate.sv
module mef_int1_gate
  import mef_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  fm_mode_e      mode_i,
  input  logic [FW-1:0] ft_n_i,
  input  logic [FW-1:0] mask_n_i,
  input  logic          ack_i,
  output logic          pend_q
);
  logic [FW-1:0] masked;
  logic          hit;
  logic          armed_q;

  always_comb begin
    masked = (mode_i == FM_MODE_B) ? (ft_n_i & mask_n_i) : ft_n_i;
    hit    = |masked;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
    end else if (armed_q && hit) begin
      pend_q  <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      if (!hit)  armed_q <= 1'b1;
      if (ack_i) pend_q  <= 1'b0;
    end
  end

  AST_SET_DISARMS: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> !armed_q); // R6

  AST_DISARMED_NO_SET: assert property (@(posedge clk) disable iff (rst)
    !armed_q |=> !$rose(pend_q)); // R6

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !armed_q) |=> !pend_q); // R8
endmodule

// File: rtl/mef_capture.sv
module mef_capture
  import mef_pkg::*;
#(
  parameter int FW          = 16,
  parameter int PS_W        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int PRIV_BIT    = 10,
  parameter int MPROT_BIT   = 3,
  parameter int EXAD_BIT    = 5,
  parameter int PAR_BIT     = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            as_i,
  input  logic [FW-1:0]   flt_i,
  input  logic            priv_chk_i,
  input  logic [PS_W-1:0] ps_i,
  input  logic            b_mode_i,
  input  logic            fmask_we_i,
  input  logic [FW-1:0]   fmask_wd_i,
  input  logic            ft_clr_i,
  input  logic            svc_ack_i,
  output logic [FW-1:0]   ft_o,
  output logic [FW-1:0]   fmask_o,
  output logic            pend1_o,
  output logic            abort_cur_o,
  output logic            abort_next_o
);
  logic          strobe_fall;
  logic          priv_viol;
  logic [FW-1:0] ft_next;
  logic [FW-1:0] mask_next;
  fm_mode_e      mode;

  assign priv_viol = priv_chk_i & (ps_i != '0);
  assign mode      = fm_mode_e'(b_mode_i);

  mef_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .as_i   (as_i),
    .fall_o (strobe_fall)
  );

  mef_fault_store #(
    .FW(FW), .PRIV_BIT(PRIV_BIT), .MPROT_BIT(MPROT_BIT),
    .EXAD_BIT(EXAD_BIT), .PAR_BIT(PAR_BIT)
  ) u_store (
    .clk          (clk),
    .rst          (rst),
    .fall_i       (strobe_fall),
    .flt_i        (flt_i),
    .priv_i       (priv_viol),
    .clr_i        (ft_clr_i),
    .mask_we_i    (fmask_we_i),
    .mask_wd_i    (fmask_wd_i),
    .ft_q         (ft_o),
    .mask_q       (fmask_o),
    .ft_n         (ft_next),
    .mask_n       (mask_next),
    .abort_cur_q  (abort_cur_o),
    .abort_next_q (abort_next_o)
  );

  mef_int1_gate #(.FW(FW)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .mode_i   (mode),
    .ft_n_i   (ft_next),
    .mask_n_i (mask_next),
    .ack_i    (svc_ack_i),
    .pend_q   (pend1_o)
  );

  AST_PEND_NEEDS_FAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(pend1_o) |-> (ft_o != '0)); // R4

  AST_PRIV_SETS_BIT: assert property (@(posedge clk) disable iff (rst)
    priv_viol |=> ft_o[PRIV_BIT]); // R3
endmodule

// File: tb/sim_mef_capture.sv
module sim_mef_capture;
  localparam int FW = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_i = 1'b1;
  logic [FW-1:0] flt_i = '0;
  logic priv_chk_i = 1'b0;
  logic [3:0] ps_i = '0;
  logic b_mode_i = 1'b0;
  logic fmask_we_i = 1'b0;
  logic [FW-1:0] fmask_wd_i = '0;
  logic ft_clr_i = 1'b0;
  logic svc_ack_i = 1'b0;
  logic [FW-1:0] ft_o, fmask_o;
  logic pend1_o, abort_cur_o, abort_next_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mef_capture u0 (
    .clk(clk), .rst(rst), .as_i(as_i), .flt_i(flt_i), .priv_chk_i(priv_chk_i),
    .ps_i(ps_i), .b_mode_i(b_mode_i), .fmask_we_i(fmask_we_i), .fmask_wd_i(fmask_wd_i),
    .ft_clr_i(ft_clr_i), .svc_ack_i(svc_ack_i), .ft_o(ft_o), .fmask_o(fmask_o),
    .pend1_o(pend1_o), .abort_cur_o(abort_cur_o), .abort_next_o(abort_next_o)
  );

  // behavioural reference model
  int q[$];
  logic [FW-1:0] m_ft, m_mask, nft, masked;
  bit m_pend, m_armed, m_ac, m_an, fall_m;

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_ft = '0; m_mask = '1; m_pend = 0; m_armed = 1; m_ac = 0; m_an = 0;
      q = {};
      for (int i = 0; i <= SYNC; i++) q.push_back(1);
    end else begin
      fall_m = (q[SYNC] == 1) && (q[SYNC-1] == 0);
      nft = ft_clr_i ? '0 : m_ft;
      if (fall_m) nft = nft | flt_i;
      if (priv_chk_i && ps_i != 0) nft[10] = 1'b1;
      if (fmask_we_i) m_mask = fmask_wd_i;
      m_ft = nft;
      masked = b_mode_i ? (nft & m_mask) : nft;
      if (m_armed && masked != 0) begin
        m_pend = 1; m_armed = 0;
      end else begin
        if (masked == 0) m_armed = 1;
        if (svc_ack_i) m_pend = 0;
      end
      m_ac = fall_m && (flt_i[3] || flt_i[5]);
      m_an = fall_m && flt_i[2];
      q.push_front(int'(as_i));
      void'(q.pop_back());
    end
    started = 1;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (started && !rst && !done) begin
      chk("R2", "ft_o", 32'(ft_o), 32'(m_ft));
      chk("R5", "fmask_o", 32'(fmask_o), 32'(m_mask));
      chk("R4", "pend1_o", 32'(pend1_o), 32'(m_pend));
      chk("R9", "abort_cur_o", 32'(abort_cur_o), 32'(m_ac));
      chk("R9", "abort_next_o", 32'(abort_next_o), 32'(m_an));
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(input logic [FW-1:0] v);
    @(negedge clk);
    flt_i = v; as_i = 1'b0;
    @(negedge clk);
    as_i = 1'b1;
    tick(SYNC + 2);
    flt_i = '0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1: reset values
    chk("R1", "ft_o reset", 32'(ft_o), 32'h0);
    chk("R1", "fmask_o reset", 32'(fmask_o), 32'hFFFF);
    chk("R1", "pend1_o reset", 32'(pend1_o), 32'h0);
    chk("R1", "abort reset", 32'({abort_cur_o, abort_next_o}), 32'h0);

    // R2 R4 R9: memory-protect fault in A mode
    strobe(16'h0008);
    chk("R2", "ft_o after capture", 32'(ft_o), 32'h0008);
    chk("R4", "pend1_o after capture", 32'(pend1_o), 32'h1);

    // R8 then R6: service, same fault again must not re-request
    svc_ack_i = 1'b1; tick(1); svc_ack_i = 1'b0;
    chk("R8", "pend1_o after ack", 32'(pend1_o), 32'h0);
    strobe(16'h0008);
    chk("R6", "pend1_o no repeat", 32'(pend1_o), 32'h0);

    // R2: fault lines toggle without strobe
    flt_i = 16'hFFFF; tick(6); flt_i = '0; tick(1);
    chk("R2", "ft_o without strobe", 32'(ft_o), 32'h0008);

    // R7 then R6 rearm: clear and capture parity
    ft_clr_i = 1'b1; tick(1); ft_clr_i = 1'b0; tick(1);
    chk("R7", "ft_o cleared", 32'(ft_o), 32'h0);
    strobe(16'h0004);
    chk("R6", "pend1_o rearmed", 32'(pend1_o), 32'h1);

    // R3: privilege check with zero and nonzero state
    svc_ack_i = 1'b1; tick(1); svc_ack_i = 1'b0;
    priv_chk_i = 1'b1; ps_i = 4'd0; tick(1); priv_chk_i = 1'b0; tick(1);
    chk("R3", "ps zero ignored", 32'(ft_o), 32'h0004);
    priv_chk_i = 1'b1; ps_i = 4'd3; tick(1); priv_chk_i = 1'b0; ps_i = 4'd0;
    chk("R3", "priv bit set", 32'(ft_o[10]), 32'h1);

    // R5: B mode, mask blocks then releases
    ft_clr_i = 1'b1; tick(1); ft_clr_i = 1'b0;
    b_mode_i = 1'b1;
    fmask_we_i = 1'b1; fmask_wd_i = 16'h0000; tick(1); fmask_we_i = 1'b0;
    tick(2);
    strobe(16'h0080);
    chk("R5", "masked no request", 32'(pend1_o), 32'h0);
    chk("R5", "ft_o holds bit", 32'(ft_o), 32'h0080);
    fmask_we_i = 1'b1; fmask_wd_i = 16'h0080; tick(1); fmask_we_i = 1'b0;
    chk("R5", "mask release request", 32'(pend1_o), 32'h1);

    // R8: ack held across a capture, set wins
    ft_clr_i = 1'b1; svc_ack_i = 1'b1; tick(2); ft_clr_i = 1'b0;
    b_mode_i = 1'b0;
    strobe(16'h0020);
    svc_ack_i = 1'b0;

    // R7: clear held across a capture, captured bits survive
    svc_ack_i = 1'b1; tick(1); svc_ack_i = 1'b0;
    ft_clr_i = 1'b1;
    strobe(16'h0101);
    ft_clr_i = 1'b0; tick(3);

    done = 1;
    summary();
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    done = 1;
    summary();
  end
endmodule